// File: doc/BRIEF.md
# Two-Byte-Fetch Protocol Microsequencer

This block is the control engine of a token-passing network controller. It walks a small microprogram held in an on-chip read-only store of 8-bit words. Each instruction takes two words: an opcode and an immediate byte. They are fetched on consecutive cycles of the fast clock, and the instruction then acts in the next execute slot. A half-rate enable, `exec_slot`, marks the execute slots.

The datapath sees the instructions only through one-cycle action strobes and a held copy of the immediate byte. A wait opcode freezes the program counter for a timed number of execute slots. Jump opcodes, either unconditional or tested against one of four external condition lines, reload the program counter. A timeout from the reconfiguration timer overrides everything else: the program counter is forced to zero, the instruction in progress is discarded, and a sticky diagnostic flag is raised until software acknowledges it.

The microprogram comes in as a parameter array. Store addresses past the end of that array read as the wait encoding 0x00.

Top module: `usq_core`

## Requirements
- R1: While reset is held, `pc` is 0, `ctl_stb` is 0, `ctl_imm` is 0 and `recon_flag` is 0. After release, the first fetch reads address 0.
- R2: An opcode byte is fetched on a fast-clock edge where `exec_slot` is 1, and the immediate byte is fetched on the next edge. Each fetch advances `pc` by one. The instruction acts on the next edge where `exec_slot` is 1, and that same edge fetches the next opcode.
- R3: Opcodes 0x01 to 0x3F are actions. When one executes, bit opc[2:0] of `ctl_stb` is high for exactly one fast cycle and `ctl_imm` takes the immediate byte, which it holds until the next action.
- R4: Opcode 0x00 is a wait. After it executes, `pc` stays unchanged for W execute slots, where W is the immediate value, or 1 when the immediate is 0. It raises no strobe.
- R5: Opcodes 0x40 to 0x43 jump unconditionally. The next opcode is fetched from address {opc[1:0], imm}. A target at or beyond the store depth is replaced by address 0.
- R6: Opcodes 0x80 to 0xFF jump, with the same target rule as R5, only when `cond[opc[6:5]]` is 1. Otherwise execution continues in sequence.
- R7: Opcodes 0x44 to 0x7F have no effect beyond sequential advance: no strobe, no change to `ctl_imm`, no redirect.
- R8: A cycle with `recon_to` high sets `pc` to 0, clears the strobes and discards any fetched or waiting instruction. It takes priority over every other action, and the next execute slot fetches address 0.
- R9: `recon_flag` is set by `recon_to` and held until a `flag_ack` cycle without `recon_to`. When both are high on the same edge, the flag is set.
- R10: The fetch after address ROM_DEPTH-1 reads address 0. Store words past the end of the loaded program read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one fetch per edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_slot | input | 1 | Half-rate execute-slot enable, alternating each cycle |
| recon_to | input | 1 | Reconfiguration timer expiry |
| flag_ack | input | 1 | Status-read acknowledge; clears `recon_flag` |
| cond | input | 4 | Condition lines tested by conditional jumps |
| pc | output | AW ($clog2(ROM_DEPTH)) | Program counter |
| ctl_stb | output | STB_N | One-hot action strobes to the datapath |
| ctl_imm | output | 8 | Immediate byte of the latest action |
| recon_flag | output | 1 | Sticky reconfiguration diagnostic bit |

## Verification
The bench builds the block with a 48-word store and an 18-byte program. A full pass through the store, including the wrap at address 47, then takes only a few hundred cycles. The program contains one jump target above the depth and a stretch of unloaded padding, so the redirect-to-zero rule and the read-as-0x00 rule are both reached. The four condition lines are set per scenario, so that a taken and a skipped branch, and a branch that picks bit 1 out of a mixed pattern, all steer different strobe sets. Timeouts and acknowledges land at chosen cycles, some of them together. A cycle-by-cycle model of the requirements follows the program counter through each run.

// File: rtl/usq_pkg.sv
package usq_pkg;

   localparam int WORD_W = 8;
   localparam int COND_N = 4;

   typedef enum logic [1:0] {
      K_WAIT,
      K_ACT,
      K_JUMP,
      K_NONE
   } usq_kind_t;

   typedef enum logic [1:0] {
      S_OPC,
      S_IMM,
      S_HOLD
   } usq_state_t;

endpackage

// File: rtl/usq_rom.sv
module usq_rom #(
   parameter int DEPTH = 544,
   parameter int AW = 10,
   parameter int PLEN = 16,
   parameter logic [7:0] PROG [PLEN] = '{default: 8'h00}
) (
   input  logic [AW-1:0] addr,
   output logic [7:0]    data
);

   localparam int PIW = (PLEN > 1) ? $clog2(PLEN) : 1;

   if (PLEN < 2) begin : g_bad_len
      $error("usq_rom: program must hold at least two bytes");
   end

   logic [PIW-1:0] idx;
   assign idx = PIW'(addr);

   if (PLEN >= DEPTH) begin : g_full
      // program covers the whole store
      assign data = PROG[idx];
   end else begin : g_pad
      // R10: unloaded words read as the wait encoding
      assign data = (int'(addr) < PLEN) ? PROG[idx] : 8'h00;
   end

endmodule

// File: rtl/usq_decode.sv
module usq_decode #(
   parameter int DEPTH = 544,
   parameter int AW = 10,
   parameter int STB_N = 8
) (
   input  logic [7:0]                   opc,
   input  logic [7:0]                   imm,
   input  logic [usq_pkg::COND_N-1:0]   cond,
   output usq_pkg::usq_kind_t           kind,
   output logic                         taken,
   output logic [AW-1:0]                target,
   output logic [STB_N-1:0]             stb_vec
);
   import usq_pkg::*;

   logic [9:0] raw_tgt;

   always_comb begin
      if (opc == 8'h00)             kind = K_WAIT;
      else if (opc[7])              kind = K_JUMP;
      else if (opc[7:6] == 2'b00)   kind = K_ACT;
      else if (opc[7:2] == 6'b010000) kind = K_JUMP;
      else                          kind = K_NONE;
   end

   // conditional jumps test one selected line, unconditional always go
   assign taken = opc[7] ? cond[opc[6:5]] : (kind == K_JUMP);

   assign raw_tgt = {opc[1:0], imm};
   assign target  = (int'(raw_tgt) < DEPTH) ? AW'(raw_tgt) : '0;

   for (genvar i = 0; i < STB_N; i++) begin : g_stb
      assign stb_vec[i] = (kind == K_ACT) && (opc[2:0] == 3'(i));
   end

endmodule

// File: rtl/usq_waitcnt.sv
module usq_waitcnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_val == '0) ? CW'(1) : load_val;
      end else if (tick && cnt_q > CW'(1)) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign last = (cnt_q == CW'(1));

   // a started wait always has at least one slot to run
   assert_wait_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q != '0));

endmodule

// File: rtl/usq_core.sv
module usq_core #(
   parameter int ROM_DEPTH = 544,
   parameter int PROG_LEN = 16,
   parameter logic [7:0] PROG [PROG_LEN] = '{default: 8'h00},
   parameter int STB_N = 8,
   localparam int AW = $clog2(ROM_DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        exec_slot,
   input  logic                        recon_to,
   input  logic                        flag_ack,
   input  logic [usq_pkg::COND_N-1:0]  cond,
   output logic [AW-1:0]               pc,
   output logic [STB_N-1:0]            ctl_stb,
   output logic [7:0]                  ctl_imm,
   output logic                        recon_flag
);
   import usq_pkg::*;

   if (ROM_DEPTH < 2 || ROM_DEPTH > 1024) begin : g_bad_depth
      $error("usq_core: ROM_DEPTH must lie in 2..1024");
   end
   if (STB_N < 1 || STB_N > 8) begin : g_bad_stb
      $error("usq_core: STB_N must lie in 1..8");
   end

   usq_state_t     st_q;
   logic [AW-1:0]  pc_q;
   logic [7:0]     opc_q, imm_q, cimm_q;
   logic           have_q, flag_q;
   logic [STB_N-1:0] stb_q;

   usq_kind_t      kind;
   logic           taken, wait_last;
   logic [AW-1:0]  target, fetch_a;
   logic [STB_N-1:0] stb_vec;
   logic [7:0]     rom_d;
   logic           exec_now, start_wait;

   function automatic logic [AW-1:0] next_a(input logic [AW-1:0] a);
      return (int'(a) == ROM_DEPTH - 1) ? '0 : a + 1'b1;
   endfunction

   usq_decode #(.DEPTH(ROM_DEPTH), .AW(AW), .STB_N(STB_N)) u_dec (
      .opc     (opc_q),
      .imm     (imm_q),
      .cond    (cond),
      .kind    (kind),
      .taken   (taken),
      .target  (target),
      .stb_vec (stb_vec)
   );

   assign exec_now   = (st_q == S_OPC) && exec_slot && have_q;
   assign start_wait = exec_now && (kind == K_WAIT);
   assign fetch_a    = ((st_q == S_OPC) && have_q && taken) ? target : pc_q;

   usq_rom #(.DEPTH(ROM_DEPTH), .AW(AW), .PLEN(PROG_LEN), .PROG(PROG)) u_rom (
      .addr (fetch_a),
      .data (rom_d)
   );

   usq_waitcnt #(.CW(WORD_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (recon_to),
      .load     (start_wait),
      .load_val (imm_q),
      .tick     (exec_slot && (st_q == S_HOLD)),
      .last     (wait_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_OPC;
         pc_q   <= '0;
         opc_q  <= 8'h00;
         imm_q  <= 8'h00;
         have_q <= 1'b0;
         stb_q  <= '0;
         cimm_q <= 8'h00;
         flag_q <= 1'b0;
      end else if (recon_to) begin
         // R8: restart from address zero, drop everything in flight
         st_q   <= S_OPC;
         pc_q   <= '0;
         opc_q  <= 8'h00;
         imm_q  <= 8'h00;
         have_q <= 1'b0;
         stb_q  <= '0;
         flag_q <= 1'b1;
      end else begin
         stb_q <= '0;
         if (flag_ack) flag_q <= 1'b0;
         unique case (st_q)
            S_OPC: if (exec_slot) begin
               if (start_wait) begin
                  st_q   <= S_HOLD;
                  have_q <= 1'b0;
               end else begin
                  if (exec_now && kind == K_ACT) begin
                     stb_q  <= stb_vec;
                     cimm_q <= imm_q;
                  end
                  opc_q  <= rom_d;
                  pc_q   <= next_a(fetch_a);
                  have_q <= 1'b0;
                  st_q   <= S_IMM;
               end
            end
            S_IMM: begin
               imm_q  <= rom_d;
               pc_q   <= next_a(pc_q);
               have_q <= 1'b1;
               st_q   <= S_OPC;
            end
            S_HOLD: if (exec_slot && wait_last) begin
               opc_q <= rom_d;
               pc_q  <= next_a(pc_q);
               st_q  <= S_IMM;
            end
            default: st_q <= S_OPC;
         endcase
      end
   end

   assign pc         = pc_q;
   assign ctl_stb    = stb_q;
   assign ctl_imm    = cimm_q;
   assign recon_flag = flag_q;

   assert_timeout_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      recon_to |=> (pc == '0 && ctl_stb == '0 && recon_flag));

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (recon_flag && !flag_ack) |=> recon_flag);

   assert_flag_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ack && !recon_to) |=> !recon_flag);

   assert_strobe_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_stb != '0) |-> ($past(exec_slot) && $onehot0(ctl_stb)));

   assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_HOLD && !recon_to && !(exec_slot && wait_last)) |=> $stable(pc));

   assert_pc_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pc) < ROM_DEPTH);

endmodule

// File: tb/sim_usq_core.sv
module sim_usq_core;

   localparam int BD = 48;
   localparam int BL = 18;
   localparam logic [7:0] TPROG [BL] = '{
      8'h05, 8'hA5,   // 0: action, strobe bit 5
      8'h00, 8'h03,   // 2: wait three slots
      8'hA0, 8'h0A,   // 4: jump to 10 if cond[1]
      8'h01, 8'h11,   // 6: action, strobe bit 1
      8'h40, 8'h0C,   // 8: jump to 12
      8'h02, 8'h22,   // 10: action, strobe bit 2
      8'h00, 8'h00,   // 12: wait one slot
      8'h50, 8'h77,   // 14: reserved opcode
      8'hE3, 8'hFF    // 16: jump if cond[3], target beyond depth
   };

   typedef struct packed {
      logic [3:0]  cnd;
      logic [15:0] to_c;
      logic [15:0] ack_c;
      logic [7:0]  mask;
      logic        flag;
      logic        wrap;
   } row_t;

   localparam row_t ROWS [6] = '{
      '{4'b0000, 16'd0,  16'd0,  8'h22, 1'b0, 1'b1},
      '{4'b0010, 16'd0,  16'd0,  8'h24, 1'b0, 1'b1},
      '{4'b1101, 16'd0,  16'd0,  8'h22, 1'b0, 1'b0},
      '{4'b0010, 16'd20, 16'd0,  8'h24, 1'b1, 1'b1},
      '{4'b0000, 16'd40, 16'd60, 8'h22, 1'b0, 1'b1},
      '{4'b0000, 16'd50, 16'd50, 8'h22, 1'b1, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_slot = 1'b0;
   logic       recon_to = 1'b0;
   logic       flag_ack = 1'b0;
   logic [3:0] cond = 4'b0;
   logic [5:0] pc;
   logic [7:0] ctl_stb;
   logic [7:0] ctl_imm;
   logic       recon_flag;

   int nchk = 0;
   int nerr = 0;
   int k = 0;
   bit done = 0;

   always #10 clk = ~clk;

   usq_core #(.ROM_DEPTH(BD), .PROG_LEN(BL), .PROG(TPROG), .STB_N(8)) u0 (
      .clk(clk), .rst_n(rst_n), .exec_slot(exec_slot), .recon_to(recon_to),
      .flag_ack(flag_ack), .cond(cond), .pc(pc), .ctl_stb(ctl_stb),
      .ctl_imm(ctl_imm), .recon_flag(recon_flag)
   );

   // reference model built from the requirements, at slot level
   int         m_pc, m_wait, m_ph;
   logic [7:0] m_op, m_im, m_stb, m_cimm;
   logic       m_have, m_flag;

   function automatic logic [7:0] rd(input int a);
      return (a < BL) ? TPROG[a] : 8'h00;
   endfunction
   function automatic int inc(input int a);
      return (a == BD - 1) ? 0 : a + 1;
   endfunction

   always @(posedge clk) begin
      int tg;
      bit jmp;
      if (!rst_n) begin
         m_pc <= 0; m_wait <= 0; m_ph <= 0; m_op <= 0; m_im <= 0;
         m_stb <= 0; m_cimm <= 0; m_have <= 0; m_flag <= 0;
      end else if (recon_to) begin
         m_pc <= 0; m_wait <= 0; m_ph <= 0; m_op <= 0; m_im <= 0;
         m_stb <= 0; m_have <= 0; m_flag <= 1;
      end else begin
         m_stb <= 0;
         if (flag_ack) m_flag <= 0;
         if (m_ph == 0 && exec_slot) begin
            tg = {m_op[1:0], m_im};
            if (tg >= BD) tg = 0;
            jmp = m_have && ((m_op[7] && cond[m_op[6:5]]) || (m_op[7:2] == 6'b010000));
            if (m_have && m_op == 8'h00) begin
               m_wait <= (m_im == 0) ? 1 : int'(m_im);
               m_ph <= 2; m_have <= 0;
            end else begin
               if (m_have && m_op[7:6] == 2'b00) begin
                  m_stb <= 8'h01 << m_op[2:0];
                  m_cimm <= m_im;
               end
               m_op <= rd(jmp ? tg : m_pc);
               m_pc <= inc(jmp ? tg : m_pc);
               m_ph <= 1; m_have <= 0;
            end
         end else if (m_ph == 1) begin
            m_im <= rd(m_pc); m_pc <= inc(m_pc); m_have <= 1; m_ph <= 0;
         end else if (m_ph == 2 && exec_slot) begin
            if (m_wait == 1) begin
               m_op <= rd(m_pc); m_pc <= inc(m_pc); m_ph <= 1;
            end else m_wait <= m_wait - 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic to, input logic ack);
      exec_slot = ~k[0];
      recon_to = to;
      flag_ack = ack;
      @(posedge clk);
      @(negedge clk);
      k++;
      chk("R2 pc trace", 32'(pc), 32'(m_pc));
      chk("R3 strobes", 32'(ctl_stb), 32'(m_stb));
      chk("R3 immediate", 32'(ctl_imm), 32'(m_cimm));
      chk("R9 flag", 32'(recon_flag), 32'(m_flag));
      recon_to = 1'b0;
      flag_ack = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; recon_to = 1'b0; flag_ack = 1'b0; exec_slot = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 reset pc", 32'(pc), 32'd0);
      chk("R1 reset strobes", 32'(ctl_stb), 32'd0);
      chk("R1 reset imm", 32'(ctl_imm), 32'd0);
      chk("R1 reset flag", 32'(recon_flag), 32'd0);
      rst_n = 1'b1;
      k = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      logic [7:0] seen;
      bit wrapped;
      int prev;

      // table walk
      for (int r = 0; r < 6; r++) begin
         cond = ROWS[r].cnd;
         do_reset();
         seen = 0; wrapped = 0; prev = 0;
         for (int c = 1; c <= 300; c++) begin
            step(c == int'(ROWS[r].to_c), c == int'(ROWS[r].ack_c));
            seen |= ctl_stb;
            if (prev == BD - 1 && pc == 0 && c != int'(ROWS[r].to_c)) wrapped = 1;
            prev = int'(pc);
         end
         chk("R5 R6 R7 strobe set", 32'(seen), 32'(ROWS[r].mask));
         chk("R9 final flag", 32'(recon_flag), 32'(ROWS[r].flag));
         chk("R10 wrap seen", 32'(wrapped), 32'(ROWS[r].wrap));
      end

      // directed: fetch pairing and wait stall
      cond = 4'b0000;
      do_reset();
      repeat (3) step(0, 0);
      chk("R2 pc after first execute", 32'(pc), 32'd3);
      chk("R3 first strobe", 32'(ctl_stb), 32'h20);
      chk("R3 first immediate", 32'(ctl_imm), 32'hA5);
      repeat (7) step(0, 0);
      chk("R4 pc held during wait", 32'(pc), 32'd4);
      step(0, 0);
      chk("R4 pc moves after wait", 32'(pc), 32'd5);

      // directed: timeout restart and flag handling
      do_reset();
      repeat (5) step(0, 0);
      step(1, 0);
      chk("R8 pc cleared", 32'(pc), 32'd0);
      chk("R8 flag raised", 32'(recon_flag), 32'd1);
      repeat (3) step(0, 0);
      chk("R8 restart executes address 0", 32'(ctl_stb), 32'h20);
      step(0, 1);
      chk("R9 ack clears flag", 32'(recon_flag), 32'd0);
      step(1, 1);
      chk("R9 set wins over ack", 32'(recon_flag), 32'd1);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL R2 watchdog: got hung run expected completion");
         finish_run();
      end
   end

endmodule